// File: doc/BRIEF.md
# Photovoltaic Converter Operating-Mode Sequencer

This block is the top-level controller that decides which operating mode a solar power optimiser runs in: held in reset, ramping its output during soft-start, waiting in a startup bypass, sitting in bypass (panel passed straight to the output), or running the maximum-power tracking loop. It drives one enable per downstream function: the soft-start ramp, the tracking loop and the bypass switch control. It also reports the current mode as a 3-bit code. The ramp generator and the tracking algorithm sit outside this block.

Decisions depend on a registered sample of the output current, which is compared against a high and a low threshold with hysteresis. Other inputs are a power-change flag from the tracker, a forced-bypass pin, a soft-reset bit and a one-millisecond tick. Every duration counts that tick, so a system can scale time freely. The soft-start length code and the startup hold code are captured once, on the first clock after the reset pin is released. A soft reset reruns the sequence with those captured values.

Top module: `pvmode_seq`

## Requirements
- R1: While `rst_n` is low the mode is 0 (reset) and all three enables are low. After release the mode stays 0 until the first clock edge, and then becomes 1 (soft-start).
- R2: `cfg_freq` is captured on the first edge after `rst_n` rises. The soft-start then lasts SS_FAST_MS, SS_MED_MS or SS_SLOW_MS ticks for codes 00, 01 and 1x. When that time expires without high current, the mode becomes 2 (startup bypass).
- R3: Each `iout` value is registered before it is compared. If a sample above `hi_th` is seen during soft-start, the mode becomes 4 (tracking) on the second edge after `iout` was driven, and no startup hold applies.
- R4: In startup bypass, the hold timer runs only after a sample above `hi_th` has armed it. The hold lasts 0, HOLD_UNIT_MS or 2×HOLD_UNIT_MS ticks for `cfg_hold` codes 00, 01 and 1x, and then the mode becomes 3 (bypass). `pwr_chg` has no effect in this mode.
- R5: A sample below `lo_th` does different things by mode. In startup bypass it disarms the hold and restarts it from zero. In tracking or bypass it returns the mode to 2. A sample between the two thresholds changes nothing.
- R6: In bypass, tracking is entered after RECHECK_MS ticks, or at once on `pwr_chg`. Tracking entered from bypass returns to bypass after WINDOW_MS ticks. Tracking entered from soft-start or startup bypass has no time limit.
- R7: While `force_byp_n` is low, every mode except reset moves to bypass on the next edge. Bypass then stays put with its recheck timer held at zero.
- R8: While `soft_rst` is high the mode is 0 and all enables are low. When it clears, soft-start reruns with the values captured at R2, and `cfg_freq`/`cfg_hold` are not sampled again.
- R9: `ss_en` is high only in mode 1, `trk_en` only in mode 4, and `byp_en` only in modes 2 and 3. At most one enable is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, asynchronous |
| soft_rst | input | 1 | Soft reset, holds the block idle while high |
| force_byp_n | input | 1 | Active-low forced-bypass request |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pwr_chg | input | 1 | Output power has moved by the configured fraction |
| iout | input | ADC_W | Sampled output current |
| hi_th | input | ADC_W | Upper hysteresis threshold |
| lo_th | input | ADC_W | Lower hysteresis threshold |
| cfg_freq | input | 2 | Soft-start length code (00 fast, 01 medium, 1x slow) |
| cfg_hold | input | 2 | Startup hold code (00 none, 01 one unit, 1x two units) |
| mode | output | 3 | 0 reset, 1 soft-start, 2 startup bypass, 3 bypass, 4 tracking |
| ss_en | output | 1 | Soft-start ramp enable |
| trk_en | output | 1 | Tracking loop enable |
| byp_en | output | 1 | Bypass enable |

## Verification
The bench builds the sequencer with soft-start lengths of 4, 6 and 8 ticks, a hold unit of 10 ticks, a recheck period of 12 ticks and a tracking window of 3 ticks. At these values the one- and two-unit holds, the periodic recheck and the bounded window all complete within tens of cycles. The directed part pulses the tick on every clock, so each expiry edge can be predicted exactly. The random part gates the tick randomly and toggles the forced-bypass, soft-reset and power-change inputs, plus occasional hard resets with fresh codes. A bench model of the mode rules follows both parts cycle by cycle.

// File: rtl/pvmode_pkg.sv
package pvmode_pkg;

   typedef enum logic [2:0] {
      MS_RESET  = 3'd0,
      MS_SOFT   = 3'd1,
      MS_HOLD   = 3'd2,
      MS_BYPASS = 3'd3,
      MS_TRACK  = 3'd4
   } mode_e;

   function automatic int unsigned pick_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pvmode_cfg.sv
module pvmode_cfg
   import pvmode_pkg::*;
#(
   parameter int unsigned SS_FAST_MS   = 250,
   parameter int unsigned SS_MED_MS    = 375,
   parameter int unsigned SS_SLOW_MS   = 500,
   parameter int unsigned HOLD_UNIT_MS = 60000,
   parameter int unsigned CNT_W        = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_freq,
   input  logic [1:0]       cfg_hold,
   output logic [CNT_W-1:0] ss_lim,
   output logic [CNT_W-1:0] hold_lim
);

   localparam logic [CNT_W-1:0] L_FAST  = CNT_W'(SS_FAST_MS);
   localparam logic [CNT_W-1:0] L_MED   = CNT_W'(SS_MED_MS);
   localparam logic [CNT_W-1:0] L_SLOW  = CNT_W'(SS_SLOW_MS);
   localparam logic [CNT_W-1:0] L_HOLD1 = CNT_W'(HOLD_UNIT_MS);
   localparam logic [CNT_W-1:0] L_HOLD2 = CNT_W'(2 * HOLD_UNIT_MS);

   initial begin
      assert (SS_FAST_MS <= SS_MED_MS && SS_MED_MS <= SS_SLOW_MS)
         else $error("soft-start lengths must not decrease with code");
      assert ((64'(2 * HOLD_UNIT_MS)) < (64'd1 << CNT_W))
         else $error("timer width too small for the longest hold");
   end

   logic [1:0] freq_q;
   logic [1:0] hold_q;
   logic       cfg_ok;

   // captured once per hard reset; soft reset leaves these untouched
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_q <= '0;
         hold_q <= '0;
         cfg_ok <= 1'b0;
      end else if (!cfg_ok) begin
         freq_q <= cfg_freq;
         hold_q <= cfg_hold;
         cfg_ok <= 1'b1;
      end
   end

   always_comb begin
      unique case (freq_q)
         2'b00:   ss_lim = L_FAST;
         2'b01:   ss_lim = L_MED;
         default: ss_lim = L_SLOW;
      endcase
   end

   always_comb begin
      unique case (hold_q)
         2'b00:   hold_lim = '0;
         2'b01:   hold_lim = L_HOLD1;
         default: hold_lim = L_HOLD2;
      endcase
   end

   // R8: once captured, the codes never move until the next hard reset
   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ok |=> ($stable(freq_q) && $stable(hold_q)));

endmodule

// File: rtl/pvmode_hyst.sv
module pvmode_hyst #(
   parameter int unsigned ADC_W      = 10,
   parameter int unsigned SMP_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADC_W-1:0] iout,
   input  logic [ADC_W-1:0] hi_th,
   input  logic [ADC_W-1:0] lo_th,
   output logic             above_hi,
   output logic             below_lo
);

   initial begin
      assert (ADC_W >= 2) else $error("sample width too small");
      assert (SMP_STAGES >= 1 && SMP_STAGES <= 4) else $error("sample stages out of range");
   end

   logic [ADC_W-1:0] smp;

   generate
      if (SMP_STAGES == 1) begin : g_one
         logic [ADC_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= iout;
         end
         assign smp = r;
      end else begin : g_multi
         logic [SMP_STAGES-1:0][ADC_W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {r[SMP_STAGES-2:0], iout};
         end
         assign smp = r[SMP_STAGES-1];
      end
   endgenerate

   assign above_hi = smp > hi_th;
   assign below_lo = smp < lo_th;

   // R3: a single-stage sample reflects the port value one edge later
   generate
      if (SMP_STAGES == 1) begin : g_chk
         a_r3_sample_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (iout > hi_th) && $stable(hi_th) && !$isunknown(iout) |=> above_hi);
      end
   endgenerate

endmodule

// File: rtl/pvmode_mstimer.sv
module pvmode_mstimer #(
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (clr)                 cnt <= '0;
      else if (en && cnt != CNT_TOP) cnt <= cnt + 1'b1;
   end

   // R6: a cleared timer restarts from zero
   a_r6_tmr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   // R4: without a tick or while disarmed the timer does not advance
   a_r4_tmr_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(cnt));

endmodule

// File: rtl/pvmode_fsm.sv
module pvmode_fsm
   import pvmode_pkg::*;
#(
   parameter int unsigned CNT_W      = 17,
   parameter int unsigned RECHECK_MS = 60000,
   parameter int unsigned WINDOW_MS  = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             force_byp_n,
   input  logic             pwr_chg,
   input  logic             ms_tick,
   input  logic             above_hi,
   input  logic             below_lo,
   input  logic [CNT_W-1:0] tmr,
   input  logic [CNT_W-1:0] ss_lim,
   input  logic [CNT_W-1:0] hold_lim,
   output mode_e            st,
   output logic             tmr_clr,
   output logic             tmr_en
);

   localparam logic [CNT_W-1:0] L_RECHECK = CNT_W'(RECHECK_MS);
   localparam logic [CNT_W-1:0] L_WINDOW  = CNT_W'(WINDOW_MS);

   initial begin
      assert (WINDOW_MS >= 1 && WINDOW_MS < RECHECK_MS)
         else $error("tracking window must be shorter than recheck period");
   end

   mode_e nxt;
   logic  armed;
   logic  win;
   logic  forced;

   assign forced = !force_byp_n;

   always_comb begin
      nxt = st;
      if (soft_rst) begin
         nxt = MS_RESET;
      end else begin
         unique case (st)
            MS_RESET:  nxt = MS_SOFT;
            MS_SOFT: begin
               if (forced)               nxt = MS_BYPASS;
               else if (above_hi)        nxt = MS_TRACK;
               else if (tmr >= ss_lim)   nxt = MS_HOLD;
            end
            MS_HOLD: begin
               if (forced)                          nxt = MS_BYPASS;
               else if (!below_lo && armed && tmr >= hold_lim) nxt = MS_BYPASS;
            end
            MS_BYPASS: begin
               if (forced)                           nxt = MS_BYPASS;
               else if (below_lo)                    nxt = MS_HOLD;
               else if (pwr_chg || tmr >= L_RECHECK) nxt = MS_TRACK;
            end
            MS_TRACK: begin
               if (forced)                        nxt = MS_BYPASS;
               else if (below_lo)                 nxt = MS_HOLD;
               else if (win && tmr >= L_WINDOW)   nxt = MS_BYPASS;
            end
            default: nxt = MS_RESET;
         endcase
      end
   end

   assign tmr_clr = (nxt != st)
                  | ((st == MS_HOLD) & below_lo)
                  | ((st == MS_BYPASS) & forced);
   assign tmr_en  = ms_tick & (st != MS_RESET) & ((st != MS_HOLD) | armed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= MS_RESET;
         armed <= 1'b0;
         win   <= 1'b0;
      end else begin
         st <= nxt;
         if (st == MS_HOLD && nxt == MS_HOLD) armed <= !below_lo && (armed || above_hi);
         else                                 armed <= 1'b0;
         if (nxt == MS_TRACK && st != MS_TRACK) win <= (st == MS_BYPASS);
         else if (nxt != MS_TRACK)              win <= 1'b0;
      end
   end

   // R2: reset state always hands over to soft-start unless held by soft reset
   a_r2_to_soft: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MS_RESET && !soft_rst) |=> (st == MS_SOFT));

   // R4: an unarmed startup bypass never reaches bypass on its own
   a_r4_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MS_HOLD && !armed && force_byp_n && !soft_rst) |=> (st != MS_BYPASS));

   // R6: a power change in bypass opens a bounded tracking window
   a_r6_window_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MS_BYPASS && pwr_chg && force_byp_n && !soft_rst && !below_lo)
      |=> (st == MS_TRACK && win));

   // R7: forced bypass is reached from every running mode in one edge
   a_r7_force: assert property (@(posedge clk) disable iff (!rst_n)
      (st != MS_RESET && forced && !soft_rst) |=> (st == MS_BYPASS));

endmodule

// File: rtl/pvmode_seq.sv
module pvmode_seq
   import pvmode_pkg::*;
#(
   parameter int unsigned ADC_W        = 10,
   parameter int unsigned SMP_STAGES   = 1,
   parameter int unsigned SS_FAST_MS   = 250,
   parameter int unsigned SS_MED_MS    = 375,
   parameter int unsigned SS_SLOW_MS   = 500,
   parameter int unsigned HOLD_UNIT_MS = 60000,
   parameter int unsigned RECHECK_MS   = 60000,
   parameter int unsigned WINDOW_MS    = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             force_byp_n,
   input  logic             ms_tick,
   input  logic             pwr_chg,
   input  logic [ADC_W-1:0] iout,
   input  logic [ADC_W-1:0] hi_th,
   input  logic [ADC_W-1:0] lo_th,
   input  logic [1:0]       cfg_freq,
   input  logic [1:0]       cfg_hold,
   output logic [2:0]       mode,
   output logic             ss_en,
   output logic             trk_en,
   output logic             byp_en
);

   localparam int unsigned MAX_MS = pick_max(pick_max(pick_max(SS_FAST_MS, SS_MED_MS), SS_SLOW_MS),
                                             pick_max(pick_max(2 * HOLD_UNIT_MS, RECHECK_MS), WINDOW_MS));
   localparam int unsigned CNT_W  = $clog2(MAX_MS + 1);

   logic [CNT_W-1:0] ss_lim;
   logic [CNT_W-1:0] hold_lim;
   logic [CNT_W-1:0] tmr;
   logic             tmr_clr;
   logic             tmr_en;
   logic             above_hi;
   logic             below_lo;
   mode_e            st;

   pvmode_cfg #(
      .SS_FAST_MS   (SS_FAST_MS),
      .SS_MED_MS    (SS_MED_MS),
      .SS_SLOW_MS   (SS_SLOW_MS),
      .HOLD_UNIT_MS (HOLD_UNIT_MS),
      .CNT_W        (CNT_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_freq (cfg_freq),
      .cfg_hold (cfg_hold),
      .ss_lim   (ss_lim),
      .hold_lim (hold_lim)
   );

   pvmode_hyst #(
      .ADC_W      (ADC_W),
      .SMP_STAGES (SMP_STAGES)
   ) u_hyst (
      .clk      (clk),
      .rst_n    (rst_n),
      .iout     (iout),
      .hi_th    (hi_th),
      .lo_th    (lo_th),
      .above_hi (above_hi),
      .below_lo (below_lo)
   );

   pvmode_mstimer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .en    (tmr_en),
      .cnt   (tmr)
   );

   pvmode_fsm #(
      .CNT_W      (CNT_W),
      .RECHECK_MS (RECHECK_MS),
      .WINDOW_MS  (WINDOW_MS)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .force_byp_n (force_byp_n),
      .pwr_chg     (pwr_chg),
      .ms_tick     (ms_tick),
      .above_hi    (above_hi),
      .below_lo    (below_lo),
      .tmr         (tmr),
      .ss_lim      (ss_lim),
      .hold_lim    (hold_lim),
      .st          (st),
      .tmr_clr     (tmr_clr),
      .tmr_en      (tmr_en)
   );

   assign mode   = st;
   assign ss_en  = (st == MS_SOFT);
   assign trk_en = (st == MS_TRACK);
   assign byp_en = (st == MS_HOLD) || (st == MS_BYPASS);

   // R1: the reset pin silences everything at every edge it is low
   a_r1_pin_reset: assert property (@(posedge clk)
      !rst_n |-> (mode == 3'd0 && !ss_en && !trk_en && !byp_en));

   // R8: soft reset leaves the block idle on the following edge
   a_r8_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mode == 3'd0 && !ss_en && !trk_en && !byp_en));

   // R9: never two enables at once
   a_r9_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ss_en, trk_en, byp_en}));

endmodule

// File: tb/pvmode_seq_test.sv
module pvmode_seq_test;

   localparam int unsigned ADC_W = 10;
   localparam int unsigned SSF = 4, SSM = 6, SSS = 8;
   localparam int unsigned HU = 10, RCK = 12, WIN = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b1;
   logic             soft_rst = 1'b0;
   logic             force_byp_n = 1'b1;
   logic             ms_tick = 1'b1;
   logic             pwr_chg = 1'b0;
   logic [ADC_W-1:0] iout = '0;
   logic [ADC_W-1:0] hi_th = 10'd40;
   logic [ADC_W-1:0] lo_th = 10'd24;
   logic [1:0]       cfg_freq = 2'b00;
   logic [1:0]       cfg_hold = 2'b00;
   logic [2:0]       mode;
   logic             ss_en, trk_en, byp_en;

   int  total = 0;
   int  fails = 0;
   bit  done = 1'b0;
   bit  started = 1'b0;

   always #10 clk = ~clk;

   pvmode_seq #(
      .ADC_W (ADC_W), .SMP_STAGES (1),
      .SS_FAST_MS (SSF), .SS_MED_MS (SSM), .SS_SLOW_MS (SSS),
      .HOLD_UNIT_MS (HU), .RECHECK_MS (RCK), .WINDOW_MS (WIN)
   ) uut (
      .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst), .force_byp_n (force_byp_n),
      .ms_tick (ms_tick), .pwr_chg (pwr_chg), .iout (iout), .hi_th (hi_th), .lo_th (lo_th),
      .cfg_freq (cfg_freq), .cfg_hold (cfg_hold),
      .mode (mode), .ss_en (ss_en), .trk_en (trk_en), .byp_en (byp_en)
   );

   // ---------------- bench model of the mode rules ----------------
   function automatic int ss_ms(input logic [1:0] c);
      return (c == 2'b00) ? SSF : (c == 2'b01) ? SSM : SSS;
   endfunction

   function automatic int hold_ms(input logic [1:0] c);
      return (c == 2'b00) ? 0 : (c == 2'b01) ? HU : 2 * HU;
   endfunction

   function automatic logic [2:0] mdl_next(input logic [2:0] s, input logic hi, input logic lo,
                                           input logic fz, input logic arm, input logic w,
                                           input logic pw, input logic sr, input int t,
                                           input int ssl, input int hl);
      if (sr) return 3'd0;
      case (s)
         3'd0: return 3'd1;
         3'd1: return fz ? 3'd3 : hi ? 3'd4 : (t >= ssl) ? 3'd2 : 3'd1;
         3'd2: return fz ? 3'd3 : lo ? 3'd2 : (arm && t >= hl) ? 3'd3 : 3'd2;
         3'd3: return fz ? 3'd3 : lo ? 3'd2 : (pw || t >= RCK) ? 3'd4 : 3'd3;
         3'd4: return fz ? 3'd3 : lo ? 3'd2 : (w && t >= WIN) ? 3'd3 : 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [2:0] mdl_en(input logic [2:0] s);
      return {s == 3'd1, s == 3'd4, (s == 3'd2) || (s == 3'd3)};
   endfunction

   logic [2:0]       m_st;
   logic [ADC_W-1:0] m_iq;
   logic             m_arm, m_win, m_ok;
   logic [1:0]       m_f, m_h;
   int               m_tmr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= 3'd0; m_iq <= '0; m_arm <= 1'b0; m_win <= 1'b0;
         m_ok <= 1'b0; m_f <= 2'b00; m_h <= 2'b00; m_tmr <= 0;
      end else begin : upd
         logic hi, lo, fz, clr, en;
         logic [2:0] n;
         hi = m_iq > hi_th;
         lo = m_iq < lo_th;
         fz = !force_byp_n;
         n  = mdl_next(m_st, hi, lo, fz, m_arm, m_win, pwr_chg, soft_rst, m_tmr,
                       ss_ms(m_f), hold_ms(m_h));
         clr = (n != m_st) || (m_st == 3'd2 && lo) || (m_st == 3'd3 && fz);
         en  = ms_tick && (m_st != 3'd0) && (m_st != 3'd2 || m_arm);
         m_tmr <= clr ? 0 : en ? m_tmr + 1 : m_tmr;
         m_arm <= (m_st == 3'd2 && n == 3'd2) ? (!lo && (m_arm || hi)) : 1'b0;
         if (n == 3'd4 && m_st != 3'd4) m_win <= (m_st == 3'd3);
         else if (n != 3'd4)            m_win <= 1'b0;
         if (!m_ok) begin m_f <= cfg_freq; m_h <= cfg_hold; m_ok <= 1'b1; end
         m_iq <= iout;
         m_st <= n;
      end
   end

   // R9: every cycle the outputs match the model's mode and enables
   always @(negedge clk) begin
      if (started && rst_n && !done) begin
         total++;
         if (mode !== m_st || {ss_en, trk_en, byp_en} !== mdl_en(m_st)) begin
            fails++;
            $display("FAIL R9 model: mode=%0d en=%b expected mode=%0d en=%b",
                     mode, {ss_en, trk_en, byp_en}, m_st, mdl_en(m_st));
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_mode(input logic [2:0] exp, input string tag);
      total++;
      if (mode !== exp || {ss_en, trk_en, byp_en} !== mdl_en(exp)) begin
         fails++;
         $display("FAIL %s: mode=%0d en=%b expected mode=%0d en=%b",
                  tag, mode, {ss_en, trk_en, byp_en}, exp, mdl_en(exp));
      end
   endtask

   task automatic hard_rst(input logic [1:0] f, input logic [1:0] h);
      cfg_freq = f;
      cfg_hold = h;
      rst_n = 1'b0;
      step(2);
      expect_mode(3'd0, "R1 reset pin low");
      rst_n = 1'b1;
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: state=running expected=finished");
      report();
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'h5EED_0042));
      #2 rst_n = 1'b0;
      @(negedge clk);
      started = 1'b1;

      // R1, R2 fast soft-start, R4 zero hold, R6 recheck and window
      hard_rst(2'b00, 2'b00);
      step(1); expect_mode(3'd1, "R1 first edge after release");
      step(4); expect_mode(3'd1, "R2 fast soft-start still running");
      step(1); expect_mode(3'd2, "R2 fast soft-start expired");
      iout = 10'd100;
      step(2); expect_mode(3'd2, "R3 sample not yet acted on");
      step(1); expect_mode(3'd3, "R4 zero hold reaches bypass");
      step(12); expect_mode(3'd3, "R6 recheck not yet due");
      step(1); expect_mode(3'd4, "R6 recheck enters tracking");
      step(3); expect_mode(3'd4, "R6 window still open");
      step(1); expect_mode(3'd3, "R6 window closed");
      pwr_chg = 1'b1;
      step(1); expect_mode(3'd4, "R6 power change enters tracking");
      pwr_chg = 1'b0;
      step(4); expect_mode(3'd3, "R6 window after power change");

      // R7 forced bypass holds the recheck timer
      force_byp_n = 1'b0;
      step(20); expect_mode(3'd3, "R7 forced bypass holds");
      force_byp_n = 1'b1;

      // R5 low current and the band between thresholds
      iout = 10'd10;
      step(1); expect_mode(3'd3, "R5 low sample registered only");
      step(1); expect_mode(3'd2, "R5 low current leaves bypass");
      iout = 10'd30;
      step(30); expect_mode(3'd2, "R5 between thresholds no change");

      // R8 soft reset keeps the first captured codes
      cfg_freq = 2'b10;
      cfg_hold = 2'b01;
      soft_rst = 1'b1;
      step(1); expect_mode(3'd0, "R8 soft reset idle");
      step(3); expect_mode(3'd0, "R8 soft reset held");
      soft_rst = 1'b0;
      step(1); expect_mode(3'd1, "R8 soft-start reruns");
      step(4); expect_mode(3'd1, "R8 old length still running");
      step(1); expect_mode(3'd2, "R8 old length used");

      // R2 medium soft-start, R4 one-unit hold with power change ignored
      iout = 10'd30;
      hard_rst(2'b01, 2'b01);
      step(1); expect_mode(3'd1, "R1 release to soft-start");
      step(6); expect_mode(3'd1, "R2 medium soft-start running");
      step(1); expect_mode(3'd2, "R2 medium soft-start expired");
      iout = 10'd100;
      pwr_chg = 1'b1;
      step(12); expect_mode(3'd2, "R4 hold and power change ignored");
      pwr_chg = 1'b0;
      step(1); expect_mode(3'd3, "R4 one-unit hold expired");

      // R3 direct entry to tracking, R6 unbounded, R7 force from tracking
      iout = 10'd100;
      hard_rst(2'b10, 2'b10);
      step(1); expect_mode(3'd1, "R3 soft-start entered");
      step(1); expect_mode(3'd4, "R3 high current skips startup hold");
      step(30); expect_mode(3'd4, "R6 tracking from startup unbounded");
      force_byp_n = 1'b0;
      step(1); expect_mode(3'd3, "R7 force leaves tracking");
      force_byp_n = 1'b1;

      // R5 disarm restarts the hold
      iout = 10'd30;
      hard_rst(2'b00, 2'b01);
      step(6); expect_mode(3'd2, "R2 fast length after hard reset");
      iout = 10'd100;
      step(7);
      iout = 10'd10;
      step(2); expect_mode(3'd2, "R5 disarmed in startup bypass");
      iout = 10'd100;
      step(12); expect_mode(3'd2, "R5 hold restarted from zero");
      step(1); expect_mode(3'd3, "R5 full hold after rearm");

      // constrained random phase checked against the model
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 600) == 0) begin
            rst_n = 1'b0;
            cfg_freq = 2'($urandom);
            cfg_hold = 2'($urandom);
            step(2);
            rst_n = 1'b1;
         end
         if ((i % 20) == 0) begin
            case ($urandom % 4)
               0: iout = 10'd10;
               1: iout = 10'd30;
               2: iout = 10'd100;
               default: iout = 10'($urandom % 128);
            endcase
         end
         ms_tick     = (($urandom % 3) == 0);
         pwr_chg     = (($urandom % 25) == 0);
         force_byp_n = (($urandom % 30) != 0);
         soft_rst    = (($urandom % 250) == 0);
         step(1);
      end
      report();
   end

endmodule